// File: doc/BRIEF.md
# Bundle Buffer and Typed Dispersal

This block sits between instruction fetch and the issue ports of a statically scheduled core. Fetch hands over up to two 128-bit bundles per clock. Each bundle holds a 5-bit template and three 41-bit instruction slots. The bundles go into a small circular buffer that decouples fetch from dispersal. Every cycle the dispersal logic walks the slots of the two oldest buffered bundles in program order. It places each instruction on the next free issue lane, tagged with the execution-unit class that the template assigns to its slot.

The template controls how far a cycle's issue may go. It names the unit class of every slot, and it marks the group boundaries ("stops") after which nothing more may issue in the same cycle. Issue also ends at the first instruction whose unit class has already used its capacity for the cycle. A bundle carrying a reserved template is thrown away and flagged, and none of its slots issue. A bundle leaves the buffer once all of its slots have issued. Partial progress through the oldest bundle is kept from one cycle to the next.

Top module: `bdl_disperse`

## Requirements
- R1: A bundle is laid out as template in bits 4:0, slot 0 in bits 45:5, slot 1 in bits 86:46 and slot 2 in bits 127:87. An issued single-slot instruction appears in bits 40:0 of its lane's 82-bit data field, with bits 81:41 zero.
- R2: The buffer holds DEPTH bundles (default 8). `fetch_rdy_o` is high exactly when at least two entries are free. Bundles offered while it is low are ignored: they are never issued, and no accepted bundle is lost or duplicated.
- R3: Up to two bundles are accepted per clock. When both fetch lanes are valid, lane 0 is older than lane 1. Either lane may be valid on its own.
- R4: Instructions issue in program order, packed from lane 0 upward, up to ISSUE_W (default 6) per cycle, and only from the two oldest bundles. A bundle accepted at a clock edge drives the issue outputs during the cycle that follows that edge.
- R5: The template bits 4:1 select the slot classes, written as slot 0/1/2: 0 MEM/ALU/INT, 1 MEM/ALU/INT, 2 MEM/LX, 3 MEM/MEM/ALU, 4 MEM/FP/INT, 5 MEM/MEM/FP, 6 MEM/ALU/BR, 7 MEM/BR/BR, 8 BR/BR/BR, 9 MEM/MEM/BR, 10 MEM/FP/BR, 11 ALU/ALU/BR. Lane unit tags are ALU=0, INT=1, MEM=2, FP=3, BR=4, LX=5.
- R6: Template bit 0 places a stop after the bundle's last instruction, and layout 1 also places a stop after slot 0. Issue ends after an instruction followed by a stop, and the remaining slots issue in the next cycle.
- R7: Per-cycle capacity is MEM 2, integer (ALU and INT together) 2, FP 2, BR 3 and LX 1. The first instruction that would exceed its class capacity ends the cycle's issue.
- R8: In layout 2, slots 1 and 2 form one extended instruction with tag 5. Its lane data is {slot 2, slot 1}, and it uses one lane.
- R9: Layouts 12 to 15 are reserved. If the oldest bundle carries one, that cycle issues nothing, `illegal_o` is high for that cycle, and the bundle is discarded. If the second-oldest carries one, issue ends before it.
- R10: A bundle is freed only after all its slots have issued. A bundle that issues only partly resumes at its first unissued slot.
- R11: After reset the buffer is empty, `fetch_rdy_o` is high, no lane is valid and `illegal_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_vld_i | input | 2 | Valid for fetch lanes 1 and 0 |
| fetch_bdl0_i | input | 128 | Fetch lane 0 bundle (older) |
| fetch_bdl1_i | input | 128 | Fetch lane 1 bundle |
| fetch_rdy_o | output | 1 | At least two buffer entries free |
| iss_vld_o | output | ISSUE_W | Per-lane issue valid |
| iss_unit_o | output | 3*ISSUE_W | Per-lane unit tag |
| iss_data_o | output | 82*ISSUE_W | Per-lane instruction data |
| illegal_o | output | 1 | Oldest bundle had a reserved template |

## Verification
A bundle accepted at a rising edge shapes the issue lanes during the next cycle. The issue outputs are decoded straight from the buffer registers, so no further register lies in the path. Each later cycle of the same bundle's dispersal follows one edge after the one before. The bench drives fetch on the falling edge and releases it one falling edge later, then compares all lanes and the illegal flag at that falling edge and at each following falling edge. Ready is read at the falling edge before the accepting edge, which is also the only time the bench decides what was accepted.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

   localparam int TMPL_W  = 5;
   localparam int SLOT_W  = 41;
   localparam int BDL_W   = 128;
   localparam int XDATA_W = 2 * SLOT_W;
   localparam int NCLASS  = 5;

   typedef enum logic [2:0] {
      UT_ALU  = 3'd0,
      UT_INT  = 3'd1,
      UT_MEM  = 3'd2,
      UT_FP   = 3'd3,
      UT_BR   = 3'd4,
      UT_LX   = 3'd5,
      UT_CONT = 3'd6
   } unit_e;

   typedef struct packed {
      logic  bad;
      logic  mid_stop;
      logic  end_stop;
      unit_e u0;
      unit_e u1;
      unit_e u2;
   } tmpl_t;

   // capacity classes
   localparam logic [2:0] CL_MEM = 3'd0;
   localparam logic [2:0] CL_INT = 3'd1;
   localparam logic [2:0] CL_FP  = 3'd2;
   localparam logic [2:0] CL_BR  = 3'd3;
   localparam logic [2:0] CL_LX  = 3'd4;

   function automatic tmpl_t tmpl_decode(input logic [TMPL_W-1:0] t);
      tmpl_t d;
      d.bad      = 1'b0;
      d.mid_stop = 1'b0;
      d.end_stop = t[0];
      d.u0       = UT_MEM;
      d.u1       = UT_ALU;
      d.u2       = UT_INT;
      case (t[4:1])
         4'd0:  ;
         4'd1:  d.mid_stop = 1'b1;
         4'd2:  begin d.u1 = UT_LX;  d.u2 = UT_CONT; end
         4'd3:  begin d.u1 = UT_MEM; d.u2 = UT_ALU;  end
         4'd4:  begin d.u1 = UT_FP;  d.u2 = UT_INT;  end
         4'd5:  begin d.u1 = UT_MEM; d.u2 = UT_FP;   end
         4'd6:  begin d.u1 = UT_ALU; d.u2 = UT_BR;   end
         4'd7:  begin d.u1 = UT_BR;  d.u2 = UT_BR;   end
         4'd8:  begin d.u0 = UT_BR;  d.u1 = UT_BR;  d.u2 = UT_BR; end
         4'd9:  begin d.u1 = UT_MEM; d.u2 = UT_BR;   end
         4'd10: begin d.u1 = UT_FP;  d.u2 = UT_BR;   end
         4'd11: begin d.u0 = UT_ALU; d.u1 = UT_ALU; d.u2 = UT_BR; end
         default: d.bad = 1'b1;
      endcase
      return d;
   endfunction

   function automatic unit_e slot_unit(input tmpl_t d, input int s);
      if (s == 0) return d.u0;
      if (s == 1) return d.u1;
      return d.u2;
   endfunction

   function automatic logic [2:0] unit_class(input unit_e u);
      case (u)
         UT_MEM:         return CL_MEM;
         UT_ALU, UT_INT: return CL_INT;
         UT_FP:          return CL_FP;
         UT_BR:          return CL_BR;
         default:        return CL_LX;
      endcase
   endfunction

endpackage

// File: rtl/bdl_buffer.sv
module bdl_buffer #(
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [1:0]              push_vld_i,
   input  logic [bdl_pkg::BDL_W-1:0] push0_i,
   input  logic [bdl_pkg::BDL_W-1:0] push1_i,
   input  logic [1:0]              pop_n_i,
   output logic [bdl_pkg::BDL_W-1:0] head0_o,
   output logic [bdl_pkg::BDL_W-1:0] head1_o,
   output logic [CNT_W-1:0]        count_o,
   output logic                    rdy_o
);
   import bdl_pkg::*;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bdl_buffer: DEPTH must be a power of two, at least 4");
   end

   logic [BDL_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] count_q;
   logic [1:0]       n_push;
   logic [BDL_W-1:0] wr_first;

   assign rdy_o    = (count_q <= CNT_W'(DEPTH - 2));
   assign n_push   = rdy_o ? ({1'b0, push_vld_i[0]} + {1'b0, push_vld_i[1]}) : 2'd0;
   assign wr_first = push_vld_i[0] ? push0_i : push1_i;
   assign head0_o  = mem_q[head_q];
   assign head1_o  = mem_q[head_q + PTR_W'(1)];
   assign count_o  = count_q;

   always_ff @(posedge clk_i) begin
      if (n_push != 2'd0) mem_q[tail_q] <= wr_first;
      if (n_push == 2'd2) mem_q[tail_q + PTR_W'(1)] <= push1_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         head_q  <= head_q + PTR_W'(pop_n_i);
         tail_q  <= tail_q + PTR_W'(n_push);
         count_q <= count_q + CNT_W'(n_push) - CNT_W'(pop_n_i);
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_q <= CNT_W'(DEPTH)) else $error("buffer count above depth");

   assert_hold_when_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rdy_o |=> count_q <= $past(count_q)) else $error("buffer grew while not ready");

   assert_pop_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      CNT_W'(pop_n_i) <= count_q) else $error("freed more bundles than held");

endmodule

// File: rtl/bdl_tmpl_dec.sv
module bdl_tmpl_dec #(
   parameter int NB = 2
) (
   input  logic [NB-1:0][bdl_pkg::BDL_W-1:0] bdl_i,
   output bdl_pkg::tmpl_t [NB-1:0]           dec_o
);
   import bdl_pkg::*;

   for (genvar b = 0; b < NB; b++) begin : g_dec
      assign dec_o[b] = tmpl_decode(bdl_i[b][TMPL_W-1:0]);
   end

endmodule

// File: rtl/bdl_picker.sv
module bdl_picker #(
   parameter int ISSUE_W = 6,
   parameter int CAP_MEM = 2,
   parameter int CAP_INT = 2,
   parameter int CAP_FP  = 2,
   parameter int CAP_BR  = 3,
   parameter int CAP_LX  = 1
) (
   input  logic                                  clk_i,
   input  logic                                  rst_ni,
   input  logic [1:0]                            avail_i,
   input  logic [1:0]                            head_slot_i,
   input  logic [1:0][bdl_pkg::BDL_W-1:0]        bdl_i,
   input  bdl_pkg::tmpl_t [1:0]                  dec_i,
   output logic [ISSUE_W-1:0]                    vld_o,
   output logic [ISSUE_W-1:0][2:0]               unit_o,
   output logic [ISSUE_W-1:0][bdl_pkg::XDATA_W-1:0] data_o,
   output logic [1:0]                            pop_n_o,
   output logic [1:0]                            next_slot_o,
   output logic                                  illegal_o
);
   import bdl_pkg::*;

   if (ISSUE_W < 1 || ISSUE_W > 6) begin : g_bad_width
      $error("bdl_picker: ISSUE_W must be 1..6");
   end
   if (CAP_MEM < 1 || CAP_INT < 1 || CAP_FP < 1 || CAP_BR < 1 || CAP_LX < 1 ||
       CAP_MEM > 7 || CAP_INT > 7 || CAP_FP > 7 || CAP_BR > 7 || CAP_LX > 7) begin : g_bad_cap
      $error("bdl_picker: capacities must be 1..7");
   end

   function automatic logic [2:0] cap_of(input logic [2:0] c);
      case (c)
         CL_MEM:  return 3'(CAP_MEM);
         CL_INT:  return 3'(CAP_INT);
         CL_FP:   return 3'(CAP_FP);
         CL_BR:   return 3'(CAP_BR);
         default: return 3'(CAP_LX);
      endcase
   endfunction

   function automatic logic [SLOT_W-1:0] slot_bits(input logic [BDL_W-1:0] b, input int s);
      return b[TMPL_W + SLOT_W*s +: SLOT_W];
   endfunction

   logic                 done;
   logic [ISSUE_W-1:0]   lane_oh;
   logic [2:0]           cnt [NCLASS];
   unit_e                u;
   logic [2:0]           cl;
   logic                 last;

   always_comb begin
      done        = 1'b0;
      lane_oh     = ISSUE_W'(1);
      for (int c = 0; c < NCLASS; c++) cnt[c] = 3'd0;
      vld_o       = '0;
      unit_o      = '0;
      data_o      = '0;
      pop_n_o     = 2'd0;
      next_slot_o = head_slot_i;
      illegal_o   = 1'b0;
      u           = UT_ALU;
      cl          = CL_INT;
      last        = 1'b0;

      if (avail_i != 2'd0 && dec_i[0].bad) begin
         illegal_o   = 1'b1;
         pop_n_o     = 2'd1;
         next_slot_o = 2'd0;
         done        = 1'b1;
      end

      for (int j = 0; j < 2; j++) begin
         for (int s = 0; s < 3; s++) begin
            u  = slot_unit(dec_i[j], s);
            cl = unit_class(u);
            if (!done) begin
               if (lane_oh == '0 || 2'(j) >= avail_i || dec_i[j].bad) begin
                  done = 1'b1;
               end else if ((j == 0 && 2'(s) < head_slot_i) || u == UT_CONT) begin
                  done = 1'b0;
               end else if (cnt[cl] >= cap_of(cl)) begin
                  done = 1'b1;
               end else begin
                  for (int k = 0; k < ISSUE_W; k++) begin
                     if (lane_oh[k]) begin
                        vld_o[k]  = 1'b1;
                        unit_o[k] = u;
                        data_o[k] = (u == UT_LX) ?
                           {slot_bits(bdl_i[j], 2), slot_bits(bdl_i[j], 1)} :
                           {{SLOT_W{1'b0}}, slot_bits(bdl_i[j], s)};
                     end
                  end
                  lane_oh = lane_oh << 1;
                  cnt[cl] = cnt[cl] + 3'd1;
                  last    = (s == 2) || (u == UT_LX);
                  if (last) begin
                     pop_n_o     = pop_n_o + 2'd1;
                     next_slot_o = 2'd0;
                  end else begin
                     next_slot_o = 2'(s + 1);
                  end
                  if ((s == 0 && dec_i[j].mid_stop) || (last && dec_i[j].end_stop))
                     done = 1'b1;
               end
            end
         end
      end
   end

   logic [ISSUE_W-1:0] is_br, is_mem;
   for (genvar k = 0; k < ISSUE_W; k++) begin : g_lane_kind
      assign is_br[k]  = vld_o[k] && unit_o[k] == UT_BR;
      assign is_mem[k] = vld_o[k] && unit_o[k] == UT_MEM;
   end

   assert_packed_lanes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((vld_o + ISSUE_W'(1)) & vld_o) == '0) else $error("issue lanes not packed");

   assert_br_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(is_br) <= CAP_BR) else $error("branch capacity exceeded");

   assert_mem_cap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(is_mem) <= CAP_MEM) else $error("memory capacity exceeded");

endmodule

// File: rtl/bdl_disperse.sv
module bdl_disperse #(
   parameter int DEPTH   = 8,
   parameter int ISSUE_W = 6,
   parameter int CAP_MEM = 2,
   parameter int CAP_INT = 2,
   parameter int CAP_FP  = 2,
   parameter int CAP_BR  = 3,
   parameter int CAP_LX  = 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic [1:0]               fetch_vld_i,
   input  logic [127:0]             fetch_bdl0_i,
   input  logic [127:0]             fetch_bdl1_i,
   output logic                     fetch_rdy_o,
   output logic [ISSUE_W-1:0]       iss_vld_o,
   output logic [3*ISSUE_W-1:0]     iss_unit_o,
   output logic [82*ISSUE_W-1:0]    iss_data_o,
   output logic                     illegal_o
);
   import bdl_pkg::*;

   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [CNT_W-1:0]             count;
   logic [1:0][BDL_W-1:0]        head_bdl;
   tmpl_t [1:0]                  dec;
   logic [1:0]                   avail, pop_n, next_slot;
   logic [1:0]                   head_slot_q;
   logic [ISSUE_W-1:0][2:0]      lane_unit;
   logic [ISSUE_W-1:0][XDATA_W-1:0] lane_data;

   bdl_buffer #(.DEPTH(DEPTH)) u_buf (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_vld_i (fetch_vld_i),
      .push0_i    (fetch_bdl0_i),
      .push1_i    (fetch_bdl1_i),
      .pop_n_i    (pop_n),
      .head0_o    (head_bdl[0]),
      .head1_o    (head_bdl[1]),
      .count_o    (count),
      .rdy_o      (fetch_rdy_o)
   );

   bdl_tmpl_dec #(.NB(2)) u_dec (
      .bdl_i (head_bdl),
      .dec_o (dec)
   );

   assign avail = (count >= CNT_W'(2)) ? 2'd2 : count[1:0];

   bdl_picker #(
      .ISSUE_W (ISSUE_W), .CAP_MEM (CAP_MEM), .CAP_INT (CAP_INT),
      .CAP_FP  (CAP_FP),  .CAP_BR  (CAP_BR),  .CAP_LX  (CAP_LX)
   ) u_pick (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .avail_i     (avail),
      .head_slot_i (head_slot_q),
      .bdl_i       (head_bdl),
      .dec_i       (dec),
      .vld_o       (iss_vld_o),
      .unit_o      (lane_unit),
      .data_o      (lane_data),
      .pop_n_o     (pop_n),
      .next_slot_o (next_slot),
      .illegal_o   (illegal_o)
   );

   assign iss_unit_o = lane_unit;
   assign iss_data_o = lane_data;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) head_slot_q <= 2'd0;
      else         head_slot_q <= next_slot;
   end

   assert_illegal_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      illegal_o |-> iss_vld_o == '0) else $error("issue during illegal bundle");

   assert_resume_needs_bundle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (head_slot_q != 2'd0) |-> (count != '0)) else $error("partial slot with empty buffer");

   assert_slot_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      head_slot_q != 2'd3) else $error("resume slot out of range");

endmodule

// File: tb/bdl_disperse_tb_top.sv
`timescale 1ns/1ps
module bdl_disperse_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   fetch_vld = 2'b00;
   logic [127:0] bdl0 = '0, bdl1 = '0;
   logic         fetch_rdy, illegal;
   logic [5:0]   iss_vld;
   logic [17:0]  iss_unit;
   logic [491:0] iss_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   bdl_disperse dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .fetch_vld_i (fetch_vld), .fetch_bdl0_i (bdl0), .fetch_bdl1_i (bdl1),
      .fetch_rdy_o (fetch_rdy), .iss_vld_o (iss_vld), .iss_unit_o (iss_unit),
      .iss_data_o (iss_data), .illegal_o (illegal)
   );

   function automatic logic [127:0] mk(input logic [4:0] t, input logic [40:0] a, b, c);
      return {c, b, a, t};
   endfunction

   function automatic logic [2:0] lane_unit(input int k);
      return iss_unit[3*k +: 3];
   endfunction

   function automatic logic [81:0] lane_data(input int k);
      return iss_data[82*k +: 82];
   endfunction

   task automatic check(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_lane(input string req, input int k,
                             input logic [2:0] unit, input logic [81:0] data);
      check(req, $sformatf("lane %0d unit", k), 128'(lane_unit(k)), 128'(unit));
      check(req, $sformatf("lane %0d data", k), 128'(lane_data(k)), 128'(data));
   endtask

   task automatic push(input logic [1:0] v, input logic [127:0] a, input logic [127:0] b);
      @(negedge clk);
      fetch_vld = v; bdl0 = a; bdl1 = b;
      @(negedge clk);
      fetch_vld = 2'b00;
   endtask

   task automatic idle_check(input string req);
      @(negedge clk);
      check(req, "idle lanes", 128'(iss_vld), 128'(0));
   endtask

   // R11: reset state
   task automatic t_reset;
      check("R11", "ready after reset", 128'(fetch_rdy), 128'(1));
      check("R11", "lanes after reset", 128'(iss_vld), 128'(0));
      check("R11", "illegal after reset", 128'(illegal), 128'(0));
   endtask

   // R1 R5: single bundle MEM MEM ALU with end stop
   task automatic t_single;
      push(2'b01, mk(5'd7, 41'h11, 41'h12, 41'h13), '0);
      check("R4", "single valid", 128'(iss_vld), 128'h07);
      check_lane("R1", 0, 3'd2, 82'h11);
      check_lane("R5", 1, 3'd2, 82'h12);
      check_lane("R5", 2, 3'd0, 82'h13);
      idle_check("R10");
   endtask

   // R3 R4: two bundles, six lanes in order
   task automatic t_pair;
      push(2'b11, mk(5'd0, 41'h21, 41'h22, 41'h23), mk(5'd21, 41'h24, 41'h25, 41'h26));
      check("R4", "pair valid", 128'(iss_vld), 128'h3F);
      check_lane("R3", 0, 3'd2, 82'h21);
      check_lane("R5", 2, 3'd1, 82'h23);
      check_lane("R3", 3, 3'd2, 82'h24);
      check_lane("R5", 4, 3'd3, 82'h25);
      check_lane("R5", 5, 3'd4, 82'h26);
      idle_check("R10");
      // lane 1 alone
      push(2'b10, '0, mk(5'd7, 41'h27, 41'h28, 41'h29));
      check("R3", "lane1 alone valid", 128'(iss_vld), 128'h07);
      check_lane("R3", 0, 3'd2, 82'h27);
      idle_check("R3");
   endtask

   // R6: stop after slot 0
   task automatic t_midstop;
      push(2'b01, mk(5'd3, 41'h31, 41'h32, 41'h33), '0);
      check("R6", "midstop first cycle", 128'(iss_vld), 128'h01);
      check_lane("R6", 0, 3'd2, 82'h31);
      @(negedge clk);
      check("R10", "resume cycle", 128'(iss_vld), 128'h03);
      check_lane("R10", 0, 3'd0, 82'h32);
      check_lane("R10", 1, 3'd1, 82'h33);
      idle_check("R6");
   endtask

   // R7: capacity limits
   task automatic t_caps;
      push(2'b11, mk(5'd6, 41'h41, 41'h42, 41'h43), mk(5'd10, 41'h44, 41'h45, 41'h46));
      check("R7", "mem cap valid", 128'(iss_vld), 128'h07);
      @(negedge clk);
      check("R7", "mem cap next", 128'(iss_vld), 128'h07);
      check_lane("R7", 0, 3'd2, 82'h44);
      check_lane("R7", 2, 3'd3, 82'h46);
      idle_check("R7");
      push(2'b11, mk(5'd16, 41'h51, 41'h52, 41'h53), mk(5'd22, 41'h54, 41'h55, 41'h56));
      check("R7", "br cap valid", 128'(iss_vld), 128'h1F);
      check_lane("R7", 4, 3'd0, 82'h55);
      @(negedge clk);
      check("R10", "br resume valid", 128'(iss_vld), 128'h01);
      check_lane("R10", 0, 3'd4, 82'h56);
      idle_check("R7");
   endtask

   // R8: two-slot instruction
   task automatic t_lx;
      push(2'b01, mk(5'd5, 41'h61, 41'h62, 41'h63), '0);
      check("R8", "lx valid", 128'(iss_vld), 128'h03);
      check_lane("R8", 0, 3'd2, 82'h61);
      check_lane("R8", 1, 3'd5, {41'h63, 41'h62});
      idle_check("R8");
   endtask

   // R9: reserved templates
   task automatic t_illegal;
      push(2'b11, mk(5'd24, 41'h71, 41'h72, 41'h73), mk(5'd7, 41'h74, 41'h75, 41'h76));
      check("R9", "illegal head flag", 128'(illegal), 128'(1));
      check("R9", "illegal head lanes", 128'(iss_vld), 128'(0));
      @(negedge clk);
      check("R9", "flag drops", 128'(illegal), 128'(0));
      check("R9", "after discard valid", 128'(iss_vld), 128'h07);
      check_lane("R9", 0, 3'd2, 82'h74);
      idle_check("R9");
      push(2'b11, mk(5'd0, 41'h81, 41'h82, 41'h83), mk(5'd26, 41'h84, 41'h85, 41'h86));
      check("R9", "second illegal flag", 128'(illegal), 128'(0));
      check("R9", "stop before illegal", 128'(iss_vld), 128'h07);
      @(negedge clk);
      check("R9", "second illegal later", 128'(illegal), 128'(1));
      check("R9", "second illegal lanes", 128'(iss_vld), 128'(0));
      @(negedge clk);
      check("R9", "clear after", 128'(illegal), 128'(0));
      check("R9", "idle after", 128'(iss_vld), 128'(0));
   endtask

   // R2: fill the buffer, offered bundles while not ready must vanish
   task automatic t_fill;
      int  acc = 0, junk = 500, exp_id = 0, exp_s = 0, issued = 0;
      bit  seen_low = 0, seq_ok = 1;
      for (int cyc = 0; cyc < 40; cyc++) begin
         @(negedge clk);
         for (int k = 0; k < 6; k++) begin
            if (iss_vld[k]) begin
               if (lane_data(k) !== 82'(exp_id * 4 + exp_s)) seq_ok = 0;
               issued++;
               exp_s++;
               if (exp_s == 3) begin exp_s = 0; exp_id++; end
            end
         end
         if (cyc < 12) begin
            if (fetch_rdy) begin
               bdl0 = mk(5'd2, 41'(acc*4), 41'(acc*4+1), 41'(acc*4+2));
               bdl1 = mk(5'd2, 41'((acc+1)*4), 41'((acc+1)*4+1), 41'((acc+1)*4+2));
               acc += 2;
            end else begin
               seen_low = 1;
               bdl0 = mk(5'd2, 41'(junk*4), 41'(junk*4+1), 41'(junk*4+2));
               bdl1 = mk(5'd2, 41'((junk+1)*4), 41'((junk+1)*4+1), 41'((junk+1)*4+2));
               junk += 2;
            end
            fetch_vld = 2'b11;
         end else begin
            fetch_vld = 2'b00;
         end
      end
      check("R2", "ready dropped when full", 128'(seen_low), 128'(1));
      check("R2", "issue order of accepted only", 128'(seq_ok), 128'(1));
      check("R2", "issued count", 128'(issued), 128'(3 * acc));
      check("R2", "ready after drain", 128'(fetch_rdy), 128'(1));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_pair();
      t_midstop();
      t_caps();
      t_lx();
      t_illegal();
      t_fill();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule